// File: doc/BRIEF.md
# Lookahead Path Confidence Estimator

This block scores how far a lookahead engine may trust a path of predicted branches. For every predicted branch it forms a raw confidence level by adding two 4-bit counters, read from tables indexed by the branch address folded with the global history, to the branch predictor's own strength value. The level selects one of 37 buckets. Each bucket holds an 8-bit confidence fraction in which 255 stands for certainty. The running path confidence is the product of the fractions of every branch predicted since the path began. The block flags termination once that product drops below a threshold the lookahead engine supplies.

Resolution events train the counters and add to per-bucket tallies of resolved and mispredicted branches. A phase is a fixed number of predictions. When a phase ends, a sequential walk over the buckets turns each tally into a measured confidence, 255 times the fraction of branches that were correct. Each bucket then moves halfway from its old fraction toward the measured one, and its tallies are cleared for the next phase.

Top module: `path_conf_est`

## Requirements
- R1: On a prediction, `pred_bucket` equals, in the same cycle, the sum of the miss-clearing counter, the up/down counter and the clamped self value. It never exceeds 36.
- R2: A `pred_self` value above 6 counts as 6 in the bucket sum.
- R3: The miss-clearing counter rises by one, saturating at 15, on a correct resolution and returns to 0 on a misprediction.
- R4: The up/down counter rises by one, saturating at 15, on a correct resolution and falls by one, stopping at 0, on a misprediction. Both counters reset to 0.
- R5: Both tables are indexed by PC bits [ALIGN+IDX_W-1:ALIGN] XOR the history. PC bits below ALIGN have no effect.
- R6: `path_conf` resets to 255. `path_start` reloads 255. Each prediction sets it to the upper 8 bits of the 16-bit product of the current value and the bucket's fraction, starting from 255 when `path_start` is high in the same cycle. With neither input high, it holds its value.
- R7: `terminate` is high exactly when `path_conf` is below `thresh`.
- R8: On the PHASE_LEN-th prediction of a phase, every bucket with a nonzero resolved count takes the fraction (old + floor(255*(resolved-mispredicted)/resolved))/2. This happens within 400 cycles. Its tallies then restart from zero.
- R9: Every bucket fraction is 128 after reset. A bucket with no resolutions in a phase keeps its fraction through that phase's end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| path_start | input | 1 | Begin a new lookahead path |
| pred_valid | input | 1 | A branch is predicted on the path this cycle |
| pred_pc | input | PC_W | Address of the predicted branch |
| pred_hist | input | IDX_W | Global history at the prediction |
| pred_self | input | SELF_W | Predictor's own strength value |
| thresh | input | 8 | Termination threshold fraction |
| res_valid | input | 1 | A branch resolved this cycle |
| res_pc | input | PC_W | Address of the resolved branch |
| res_hist | input | IDX_W | History the resolved branch was predicted with |
| res_bucket | input | 6 | Bucket reported when that branch was predicted |
| res_correct | input | 1 | 1 when the prediction was correct |
| pred_bucket | output | 6 | Bucket of the current prediction |
| path_conf | output | 8 | Running path confidence fraction |
| terminate | output | 1 | Path confidence is below the threshold |

## Verification
The bench builds the block with PHASE_LEN set to 512 and keeps the other defaults. A short phase lets the random run cross several phase ends. Every later prediction then probes the re-learned fractions through `path_conf`. Resolutions land only in buckets 0 to 20, so the upper buckets have no activity in a phase and show that their fractions are kept. Directed aliasing of PC and history shows the hash, and long runs of correct resolutions drive both counters to saturation.

// File: rtl/pce_pkg.sv
package pce_pkg;
    localparam int NBKT     = 37;
    localparam int BKT_W    = 6;
    localparam int CONF_W   = 8;
    localparam int SELF_MAX = 6;
    localparam logic [CONF_W-1:0] CONF_ONE = 8'd255;

    typedef enum logic [1:0] {
        WALK_IDLE,
        WALK_LOAD,
        WALK_DIV,
        WALK_WRITE
    } walk_e;

    function automatic logic [CONF_W-1:0] frac_mul(input logic [CONF_W-1:0] a,
                                                   input logic [CONF_W-1:0] b);
        logic [2*CONF_W-1:0] p;
        p = a * b;
        return p[2*CONF_W-1:CONF_W];
    endfunction
endpackage

// File: rtl/pce_ctr_table.sv
module pce_ctr_table #(
    parameter int IDX_W         = 10,
    parameter int CTR_W         = 4,
    parameter bit RESET_ON_MISS = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_val,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_ok
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};

    logic [CTR_W-1:0] tbl_q [DEPTH];
    logic [CTR_W-1:0] tbl_d [DEPTH];
    logic [CTR_W-1:0] cur;
    logic [CTR_W-1:0] miss_val;

    assign cur = tbl_q[upd_idx];

    generate
        if (RESET_ON_MISS) begin : g_clear
            assign miss_val = '0;
        end else begin : g_step
            assign miss_val = (cur == '0) ? '0 : cur - 1'b1;
        end
    endgenerate

    always_comb begin
        tbl_d = tbl_q;
        if (upd_en) begin
            if (upd_ok) begin
                tbl_d[upd_idx] = (cur == CTR_MAX) ? cur : cur + 1'b1;
            end else begin
                tbl_d[upd_idx] = miss_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tbl_q[i] <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_val = tbl_q[rd_idx];
endmodule

// File: rtl/pce_bucket_conf.sv
module pce_bucket_conf
    import pce_pkg::*;
#(
    parameter int STAT_W    = 21,
    parameter int INIT_CONF = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BKT_W-1:0]  rd_bkt,
    output logic [CONF_W-1:0] rd_conf,
    input  logic              res_valid,
    input  logic [BKT_W-1:0]  res_bkt,
    input  logic              res_ok,
    input  logic              phase_end
);
    localparam int NUM_W = STAT_W + CONF_W;
    localparam logic [STAT_W-1:0] STAT_MAX = {STAT_W{1'b1}};

    typedef struct packed {
        walk_e             st;
        logic [BKT_W-1:0]  bidx;
        logic [2:0]        step;
        logic [NUM_W-1:0]  rem;
        logic [STAT_W-1:0] den;
        logic [CONF_W-1:0] quo;
        logic              nz;
    } walk_t;

    walk_t             w_q, w_d;
    logic [STAT_W-1:0] tot_q [NBKT];
    logic [STAT_W-1:0] tot_d [NBKT];
    logic [STAT_W-1:0] sq_q  [NBKT];
    logic [STAT_W-1:0] sq_d  [NBKT];
    logic [CONF_W-1:0] conf_q [NBKT];
    logic [CONF_W-1:0] conf_d [NBKT];

    logic [NUM_W-1:0]  trial;
    logic [CONF_W:0]   blend;

    assign trial = NUM_W'(w_q.den) << w_q.step;
    assign blend = {1'b0, conf_q[w_q.bidx]} + {1'b0, w_q.quo};

    always_comb begin
        w_d    = w_q;
        tot_d  = tot_q;
        sq_d   = sq_q;
        conf_d = conf_q;

        unique case (w_q.st)
            WALK_IDLE: begin
                if (phase_end) begin
                    w_d.st   = WALK_LOAD;
                    w_d.bidx = '0;
                end
            end
            WALK_LOAD: begin
                w_d.den  = tot_q[w_q.bidx];
                w_d.rem  = NUM_W'(tot_q[w_q.bidx] - sq_q[w_q.bidx]) * NUM_W'(CONF_ONE);
                w_d.nz   = (tot_q[w_q.bidx] != '0);
                w_d.quo  = '0;
                w_d.step = 3'd7;
                w_d.st   = WALK_DIV;
                tot_d[w_q.bidx] = '0;
                sq_d[w_q.bidx]  = '0;
            end
            WALK_DIV: begin
                if (w_q.rem >= trial) begin
                    w_d.rem          = w_q.rem - trial;
                    w_d.quo[w_q.step] = 1'b1;
                end
                if (w_q.step == 3'd0) begin
                    w_d.st = WALK_WRITE;
                end else begin
                    w_d.step = w_q.step - 3'd1;
                end
            end
            WALK_WRITE: begin
                if (w_q.nz) begin
                    conf_d[w_q.bidx] = blend[CONF_W:1];
                end
                if (w_q.bidx == BKT_W'(NBKT - 1)) begin
                    w_d.st = WALK_IDLE;
                end else begin
                    w_d.bidx = w_q.bidx + 1'b1;
                    w_d.st   = WALK_LOAD;
                end
            end
            default: w_d.st = WALK_IDLE;
        endcase

        if (res_valid && (res_bkt < BKT_W'(NBKT))) begin
            if (tot_d[res_bkt] != STAT_MAX) begin
                tot_d[res_bkt] = tot_d[res_bkt] + 1'b1;
                if (!res_ok) sq_d[res_bkt] = sq_d[res_bkt] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '{st: WALK_IDLE, default: '0};
            for (int i = 0; i < NBKT; i++) begin
                tot_q[i]  <= '0;
                sq_q[i]   <= '0;
                conf_q[i] <= CONF_W'(INIT_CONF);
            end
        end else begin
            w_q    <= w_d;
            tot_q  <= tot_d;
            sq_q   <= sq_d;
            conf_q <= conf_d;
        end
    end

    assign rd_conf = (rd_bkt < BKT_W'(NBKT)) ? conf_q[rd_bkt] : '0;
endmodule

// File: rtl/path_conf_est.sv
module path_conf_est
    import pce_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int IDX_W     = 10,
    parameter int ALIGN     = 2,
    parameter int CTR_W     = 4,
    parameter int SELF_W    = 3,
    parameter int PHASE_LEN = 524288,
    parameter int INIT_CONF = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              path_start,
    input  logic              pred_valid,
    input  logic [PC_W-1:0]   pred_pc,
    input  logic [IDX_W-1:0]  pred_hist,
    input  logic [SELF_W-1:0] pred_self,
    input  logic [7:0]        thresh,
    input  logic              res_valid,
    input  logic [PC_W-1:0]   res_pc,
    input  logic [IDX_W-1:0]  res_hist,
    input  logic [5:0]        res_bucket,
    input  logic              res_correct,
    output logic [5:0]        pred_bucket,
    output logic [7:0]        path_conf,
    output logic              terminate
);
    localparam int PH_W   = $clog2(PHASE_LEN) + 1;
    localparam int STAT_W = $clog2(PHASE_LEN) + 2;
    localparam int NTBL   = 2;

    typedef struct packed {
        logic [CONF_W-1:0] prod;
        logic [PH_W-1:0]   pcnt;
    } path_t;

    path_t             p_q, p_d;
    logic [IDX_W-1:0]  pidx, ridx;
    logic [CTR_W-1:0]  ctr_rd [NTBL];
    logic [SELF_W-1:0] self_cl;
    logic [BKT_W-1:0]  bkt;
    logic [CONF_W-1:0] bkt_conf;
    logic [CONF_W-1:0] base;
    logic              phase_end;

    assign pidx = pred_pc[ALIGN +: IDX_W] ^ pred_hist;
    assign ridx = res_pc[ALIGN +: IDX_W] ^ res_hist;

    generate
        for (genvar g = 0; g < NTBL; g++) begin : g_tbl
            pce_ctr_table #(
                .IDX_W        (IDX_W),
                .CTR_W        (CTR_W),
                .RESET_ON_MISS(g == 0)
            ) u_tbl (
                .clk    (clk),
                .rst_n  (rst_n),
                .rd_idx (pidx),
                .rd_val (ctr_rd[g]),
                .upd_en (res_valid),
                .upd_idx(ridx),
                .upd_ok (res_correct)
            );
        end
    endgenerate

    assign self_cl = (pred_self > SELF_W'(SELF_MAX)) ? SELF_W'(SELF_MAX) : pred_self;
    assign bkt     = BKT_W'(ctr_rd[0]) + BKT_W'(ctr_rd[1]) + BKT_W'(self_cl);

    assign phase_end = pred_valid && (p_q.pcnt == PH_W'(PHASE_LEN - 1));

    pce_bucket_conf #(
        .STAT_W   (STAT_W),
        .INIT_CONF(INIT_CONF)
    ) u_bconf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_bkt   (bkt),
        .rd_conf  (bkt_conf),
        .res_valid(res_valid),
        .res_bkt  (res_bucket),
        .res_ok   (res_correct),
        .phase_end(phase_end)
    );

    assign base = path_start ? CONF_ONE : p_q.prod;

    always_comb begin
        p_d      = p_q;
        p_d.prod = base;
        if (pred_valid) begin
            p_d.prod = frac_mul(base, bkt_conf);
            p_d.pcnt = phase_end ? '0 : p_q.pcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '{prod: CONF_ONE, pcnt: '0};
        end else begin
            p_q <= p_d;
        end
    end

    assign pred_bucket = bkt;
    assign path_conf   = p_q.prod;
    assign terminate   = (p_q.prod < thresh);
endmodule

// File: rtl/pce_chk.sv
module pce_chk #(
    parameter int SELF_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              path_start,
    input logic              pred_valid,
    input logic [SELF_W-1:0] pred_self,
    input logic [5:0]        pred_bucket,
    input logic [7:0]        path_conf
);
    a_r1_bucket_range: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> pred_bucket <= 6'd36);

    a_r2_self_floor: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> (pred_bucket >= ((pred_self > SELF_W'(6)) ? 6'd6 : 6'(pred_self))));

    a_r6_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !path_start |=> path_conf <= $past(path_conf));

    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (path_start && !pred_valid) |=> path_conf == 8'd255);

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!path_start && !pred_valid) |=> $stable(path_conf));
endmodule

bind path_conf_est pce_chk #(.SELF_W(SELF_W)) u_pce_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .path_start (path_start),
    .pred_valid (pred_valid),
    .pred_self  (pred_self),
    .pred_bucket(pred_bucket),
    .path_conf  (path_conf)
);

// File: tb/path_conf_est_test.sv
`timescale 1ns/1ps
module path_conf_est_test;
    localparam int PH = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        path_start = 1'b0;
    logic        pred_valid = 1'b0;
    logic [31:0] pred_pc = '0;
    logic [9:0]  pred_hist = '0;
    logic [2:0]  pred_self = '0;
    logic [7:0]  thresh = 8'd100;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic [9:0]  res_hist = '0;
    logic [5:0]  res_bucket = '0;
    logic        res_correct = 1'b0;
    logic [5:0]  pred_bucket;
    logic [7:0]  path_conf;
    logic        terminate;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int jrs_m [1024];
    int ud_m  [1024];
    int tot_m [37];
    int sq_m  [37];
    int conf_m [37];
    int prod_m = 255;
    int pcount = 0;

    always #4 clk = ~clk;

    path_conf_est #(.PHASE_LEN(PH)) uut (
        .clk(clk), .rst_n(rst_n), .path_start(path_start), .pred_valid(pred_valid),
        .pred_pc(pred_pc), .pred_hist(pred_hist), .pred_self(pred_self), .thresh(thresh),
        .res_valid(res_valid), .res_pc(res_pc), .res_hist(res_hist), .res_bucket(res_bucket),
        .res_correct(res_correct), .pred_bucket(pred_bucket), .path_conf(path_conf),
        .terminate(terminate)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int m_idx(input logic [31:0] pc, input logic [9:0] h);
        return int'(pc[11:2] ^ h);
    endfunction

    function automatic int m_bucket(input logic [31:0] pc, input logic [9:0] h, input logic [2:0] s);
        int i;
        i = m_idx(pc, h);
        return jrs_m[i] + ud_m[i] + ((s > 3'd6) ? 6 : int'(s));
    endfunction

    task automatic m_phase_end();
        for (int b = 0; b < 37; b++) begin
            if (tot_m[b] != 0) begin
                conf_m[b] = (conf_m[b] + (255 * (tot_m[b] - sq_m[b])) / tot_m[b]) / 2;
            end
            tot_m[b] = 0;
            sq_m[b] = 0;
        end
    endtask

    task automatic do_pred(input logic [31:0] pc, input logic [9:0] h, input logic [2:0] s,
                           input logic st, input string req);
        int b;
        int base;
        pred_valid = 1'b1; path_start = st; pred_pc = pc; pred_hist = h; pred_self = s;
        #1;
        b = m_bucket(pc, h, s);
        chk({req, " bucket"}, int'(pred_bucket), b);
        base = st ? 255 : prod_m;
        prod_m = (base * conf_m[b]) >> 8;
        pcount++;
        @(negedge clk);
        pred_valid = 1'b0; path_start = 1'b0;
        chk({req, " path"}, int'(path_conf), prod_m);
        chk({req, " R7 terminate"}, int'(terminate), (prod_m < int'(thresh)) ? 1 : 0);
        if (pcount == PH) begin
            pcount = 0;
            repeat (400) @(negedge clk);
            m_phase_end();
        end
    endtask

    task automatic do_res(input logic [31:0] pc, input logic [9:0] h, input int b, input logic ok);
        int i;
        res_valid = 1'b1; res_pc = pc; res_hist = h; res_bucket = 6'(b); res_correct = ok;
        i = m_idx(pc, h);
        if (ok) begin
            if (jrs_m[i] < 15) jrs_m[i]++;
            if (ud_m[i] < 15) ud_m[i]++;
        end else begin
            jrs_m[i] = 0;
            if (ud_m[i] > 0) ud_m[i]--;
        end
        tot_m[b]++;
        if (!ok) sq_m[b]++;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] pool_pc [8];
        logic [9:0]  pool_h [4];
        void'($urandom(32'd1234));
        for (int i = 0; i < 1024; i++) begin jrs_m[i] = 0; ud_m[i] = 0; end
        for (int b = 0; b < 37; b++) begin tot_m[b] = 0; sq_m[b] = 0; conf_m[b] = 128; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 reset path", int'(path_conf), 255);
        chk("R7 reset terminate", int'(terminate), 0);

        // R1 / R9: fresh index, self 3, initial fraction 128 -> 127
        do_pred(32'h0000_2000, 10'h000, 3'd3, 1'b1, "R1 R9 fresh");
        // R2: self 7 clamps to 6
        do_pred(32'h0000_2000, 10'h000, 3'd7, 1'b1, "R2 clamp");
        // R6: start without prediction reloads 255
        path_start = 1'b1;
        @(negedge clk);
        path_start = 1'b0;
        prod_m = 255;
        chk("R6 restart", int'(path_conf), 255);
        // R6: idle cycles hold
        repeat (3) @(negedge clk);
        chk("R6 hold", int'(path_conf), 255);

        // R3 R4 R5: train pcA/histA, probe through an alias with low bits set
        for (int k = 0; k < 3; k++) do_res(32'h0000_0040, 10'h005, 0, 1'b1);
        do_pred(32'h0000_0003, 10'h015, 3'd0, 1'b1, "R5 alias R3 R4 count");
        for (int k = 0; k < 20; k++) do_res(32'h0000_0040, 10'h005, 0, 1'b1);
        do_pred(32'h0000_0003, 10'h015, 3'd2, 1'b1, "R3 R4 saturate");
        do_res(32'h0000_0040, 10'h005, 1, 1'b0);
        do_pred(32'h0000_0040, 10'h005, 3'd2, 1'b1, "R3 R4 miss");
        do_res(32'h0000_0040, 10'h005, 1, 1'b0);
        do_pred(32'h0000_0040, 10'h005, 3'd0, 1'b1, "R4 second miss");

        // R6 R7: chain on a fresh index until the product falls under 40
        thresh = 8'd40;
        do_pred(32'h0000_3000, 10'h000, 3'd0, 1'b1, "R6 chain");
        for (int k = 0; k < 7; k++) do_pred(32'h0000_3000, 10'h000, 3'd0, 1'b0, "R6 R7 chain");
        thresh = 8'd100;

        // random mix over a small pool so indices collide; R8 across phase ends
        for (int i = 0; i < 8; i++) pool_pc[i] = 32'h0000_4000 + 32'(i * 20);
        for (int i = 0; i < 4; i++) pool_h[i] = 10'($urandom);
        for (int step = 0; step < 3000; step++) begin
            logic [31:0] pc;
            logic [9:0]  h;
            pc = pool_pc[$urandom % 8];
            h  = pool_h[$urandom % 4];
            if ($urandom % 2 == 0) begin
                do_pred(pc, h, 3'($urandom % 8), (($urandom % 10) == 0), "R8 random");
            end else begin
                do_res(pc, h, int'($urandom % 21), (($urandom % 4) != 0));
            end
        end

        // R9: bucket 36 never resolved, still 128 after phase ends
        for (int k = 0; k < 16; k++) do_res(32'h0000_0100, 10'h000, 2, 1'b1);
        do_pred(32'h0000_0100, 10'h000, 3'd6, 1'b1, "R9 untouched bucket");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule